// File: doc/BRIEF.md
# Segment-Map Address Translator

This block turns a 32-bit virtual address into a 28-bit physical address through two on-chip lookup tables. The first is a segment table. It is addressed by the current context number together with the virtual segment bits, and it returns a page-group number. The second is a page-entry table. It is addressed by that group number together with the virtual page bits, and it returns a 32-bit entry. The entry holds a frame number, permission flags, attribute bits and usage flags. There is no walk through memory.

Each translation is a fixed-length read-modify-write of the page-entry table, and it ends with a one-cycle `done` pulse. Several conditions are checked, and each one faults with a 2-bit cause:
- an address that falls in the unmapped middle of the address space;
- an entry that is not valid;
- a write to a page without write permission;
- a user access to a page reserved for the supervisor.

A translation that does not fault marks the entry as used. A write also marks it as modified. The cacheability flag and the space-type field are returned with the physical address.

Software keeps both tables up to date through a separate maintenance port that reads and writes single entries. A maintenance access takes priority over the translation walk and holds it back.

Top module: `segmap_xlate`

## Requirements
- R1: Virtual address bits 31:29 must be all zeros or all ones. Any other pattern completes with `fault`=1 and `fault_cause`=0 (hole). Addresses with all ones in bits 31:29 translate exactly like all zeros, and a hole fault leaves the entry unchanged.
- R2: The segment table index is {`ctx`, va[18 +: VSEG_W]}. The group number read from it is concatenated with va[17:12] to index the page-entry table. Different contexts with the same address therefore reach different entries.
- R3: An entry whose bit 31 (valid) is 0 faults with cause 1. This check outranks the write and privilege checks.
- R4: A write (`req_write`=1) to an entry whose bit 30 (write allowed) is 0 faults with cause 2. This check outranks the privilege check.
- R5: A user access (`req_user`=1) to an entry whose bit 29 (supervisor only) is 1 faults with cause 3.
- R6: A translation without a fault gives `pa` = {entry[15:0], va[11:0]}, `nc` = entry bit 28 and `space` = entry bits 27:26. On a fault, `pa`, `nc` and `space` are all zero.
- R7: A translation without a fault writes the entry back with bit 25 (used) set. On a write, bit 24 (modified) is also set. A faulting translation leaves the entry unchanged.
- R8: `done` is a one-cycle pulse that rises two clock edges after the edge that accepts the request. `req_ready` stays low from acceptance until `done`.
- R9: On the maintenance port, `mnt_sel`=0 selects the segment table and `mnt_sel`=1 selects the page-entry table. A segment write keeps only the low GRP_W bits of `mnt_wdata`. A read returns its data, zero-extended for the segment table, together with `mnt_rvalid` in the cycle after the request edge.
- R10: While `mnt_en` is high, `req_ready` is low and a pending translation makes no progress. The translation restarts its lookup once `mnt_en` falls, so it uses any table contents written during the stall, and `done` follows two edges after the last maintenance cycle.
- R11: After reset, `done`, `fault` and `mnt_rvalid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx | input | CTX_W | Current context number, captured when a request is accepted |
| req_valid | input | 1 | Translation request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request comes from user mode |
| req_ready | output | 1 | A request is accepted on this edge if valid |
| done | output | 1 | One-cycle pulse when a translation completes |
| fault | output | 1 | The completed translation faulted |
| fault_cause | output | 2 | 0 hole, 1 invalid, 2 write-protect, 3 privilege |
| pa | output | 28 | Physical address |
| nc | output | 1 | Access must bypass the cache |
| space | output | 2 | Target space type from the entry |
| mnt_en | input | 1 | Maintenance access this cycle |
| mnt_we | input | 1 | Maintenance access is a write |
| mnt_sel | input | 1 | 0 segment table, 1 page-entry table |
| mnt_idx | input | MIDX_W | Table index |
| mnt_wdata | input | 32 | Write data |
| mnt_rdata | output | 32 | Read data |
| mnt_rvalid | output | 1 | Read data is valid |

## Verification
The bench builds the block with CTX_W=3, VSEG_W=3 and GRP_W=2. This gives a 64-entry segment table and a 256-entry page-entry table, small enough for the bench to initialise every entry through the maintenance port and to mirror both tables in its reference model. With these sizes the bench can point two contexts and the all-ones alias of an address at known entries. It can also set up entries that fail several checks at once, to show the order of the checks. Finally, it can stall a pending translation with reads and writes to the very entry being translated.

// File: rtl/segmmu_pkg.sv
package segmmu_pkg;

    localparam int VA_W    = 32;
    localparam int PAGE_SH = 12;
    localparam int VPG_W   = 6;
    localparam int SEG_LSB = 18;
    localparam int PFN_W   = 16;
    localparam int PA_W    = PFN_W + PAGE_SH;
    localparam int ENT_W   = 32;

    typedef struct packed {
        logic             valid;
        logic             wr_ok;
        logic             sup_only;
        logic             no_cache;
        logic [1:0]       space;
        logic             used;
        logic             dirty;
        logic [7:0]       rsvd;
        logic [PFN_W-1:0] pfn;
    } pte_t;

    typedef enum logic [1:0] {
        CAUSE_HOLE    = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_WPROT   = 2'd2,
        CAUSE_PRIV    = 2'd3
    } cause_e;

    typedef struct packed {
        logic   hit_fault;
        cause_e cause;
    } verdict_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WB   = 2'd2
    } walk_st_e;

    // Upper three address bits must agree with each other.
    function automatic logic in_hole(logic [2:0] top);
        return !((top == 3'b000) || (top == 3'b111));
    endfunction

    // Ordered checks: hole, valid, write permission, privilege.
    function automatic verdict_t judge(logic hole, pte_t e, logic wr, logic usr);
        verdict_t v;
        v.hit_fault = 1'b1;
        v.cause     = CAUSE_HOLE;
        if (hole)                  v.cause = CAUSE_HOLE;
        else if (!e.valid)         v.cause = CAUSE_INVALID;
        else if (wr && !e.wr_ok)   v.cause = CAUSE_WPROT;
        else if (usr && e.sup_only) v.cause = CAUSE_PRIV;
        else                       v.hit_fault = 1'b0;
        return v;
    endfunction

    function automatic pte_t mark(pte_t e, logic wr);
        pte_t r;
        r      = e;
        r.used = 1'b1;
        if (wr) r.dirty = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/segmmu_table.sv
module segmmu_table #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    assign rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end
endmodule

// File: rtl/segmmu_walk.sv
module segmmu_walk
    import segmmu_pkg::*;
#(
    parameter int CTX_W  = 3,
    parameter int VSEG_W = 7,
    parameter int GRP_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [VA_W-1:0]           req_va,
    input  logic                      req_write,
    input  logic                      req_user,
    input  logic [CTX_W-1:0]          ctx,
    input  logic                      stall,
    output logic                      req_ready,
    output logic [CTX_W+VSEG_W-1:0]   seg_raddr,
    input  logic [GRP_W-1:0]          seg_rdata,
    output logic [GRP_W+VPG_W-1:0]    pt_raddr,
    input  logic [ENT_W-1:0]          pt_rdata,
    output logic                      wb_we,
    output logic [GRP_W+VPG_W-1:0]    wb_addr,
    output logic [ENT_W-1:0]          wb_data,
    output logic                      done,
    output logic                      fault,
    output logic [1:0]                fault_cause,
    output logic [PA_W-1:0]           pa,
    output logic                      nc,
    output logic [1:0]                space
);
    localparam int PT_AW = GRP_W + VPG_W;

    walk_st_e             st;
    logic [CTX_W-1:0]     ctx_q;
    logic [VSEG_W-1:0]    vseg_q;
    logic [VPG_W-1:0]     vpg_q;
    logic [PAGE_SH-1:0]   off_q;
    logic                 hole_q, wr_q, usr_q;
    pte_t                 pte_q;
    logic [PT_AW-1:0]     pidx_q;
    verdict_t             verdict;
    pte_t                 marked;
    logic                 accept;

    logic                 done_q, fault_q, nc_q;
    cause_e               cause_q;
    logic [PA_W-1:0]      pa_q;
    logic [1:0]           space_q;

    assign req_ready = (st == ST_IDLE) && !stall;
    assign accept    = req_ready && req_valid;
    assign seg_raddr = {ctx_q, vseg_q};
    assign pt_raddr  = {seg_rdata, vpg_q};

    always_comb begin
        verdict = judge(hole_q, pte_q, wr_q, usr_q);
        marked  = mark(pte_q, wr_q);
    end

    assign wb_we   = (st == ST_WB) && !stall && !verdict.hit_fault;
    assign wb_addr = pidx_q;
    assign wb_data = marked;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ctx_q   <= '0;
            vseg_q  <= '0;
            vpg_q   <= '0;
            off_q   <= '0;
            hole_q  <= 1'b0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            pte_q   <= '0;
            pidx_q  <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            cause_q <= CAUSE_HOLE;
            pa_q    <= '0;
            nc_q    <= 1'b0;
            space_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        ctx_q  <= ctx;
                        vseg_q <= req_va[SEG_LSB +: VSEG_W];
                        vpg_q  <= req_va[PAGE_SH +: VPG_W];
                        off_q  <= req_va[PAGE_SH-1:0];
                        hole_q <= in_hole(req_va[VA_W-1:VA_W-3]);
                        wr_q   <= req_write;
                        usr_q  <= req_user;
                        st     <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (!stall) begin
                        pte_q  <= pte_t'(pt_rdata);
                        pidx_q <= pt_raddr;
                        st     <= ST_WB;
                    end
                end
                ST_WB: begin
                    if (stall) begin
                        st <= ST_LOOK;
                    end else begin
                        done_q  <= 1'b1;
                        fault_q <= verdict.hit_fault;
                        cause_q <= verdict.cause;
                        if (verdict.hit_fault) begin
                            pa_q    <= '0;
                            nc_q    <= 1'b0;
                            space_q <= '0;
                        end else begin
                            pa_q    <= {pte_q.pfn, off_q};
                            nc_q    <= pte_q.no_cache;
                            space_q <= pte_q.space;
                        end
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign done        = done_q;
    assign fault       = fault_q;
    assign fault_cause = cause_q;
    assign pa          = pa_q;
    assign nc          = nc_q;
    assign space       = space_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R7
    wb_match_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wb_we) == !fault));

    // R6
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (pa == '0 && !nc && space == 2'b00));
endmodule

// File: rtl/segmap_xlate.sv
module segmap_xlate
    import segmmu_pkg::*;
#(
    parameter int CTX_W  = 3,
    parameter int VSEG_W = 7,
    parameter int GRP_W  = 4,
    parameter int MIDX_W = ((CTX_W + VSEG_W) > (GRP_W + 6)) ? (CTX_W + VSEG_W) : (GRP_W + 6)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTX_W-1:0]  ctx,
    input  logic              req_valid,
    input  logic [31:0]       req_va,
    input  logic              req_write,
    input  logic              req_user,
    output logic              req_ready,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_cause,
    output logic [27:0]       pa,
    output logic              nc,
    output logic [1:0]        space,
    input  logic              mnt_en,
    input  logic              mnt_we,
    input  logic              mnt_sel,
    input  logic [MIDX_W-1:0] mnt_idx,
    input  logic [31:0]       mnt_wdata,
    output logic [31:0]       mnt_rdata,
    output logic              mnt_rvalid
);
    localparam int SEG_AW = CTX_W + VSEG_W;
    localparam int PT_AW  = GRP_W + VPG_W;

    logic [SEG_AW-1:0] walk_seg_ra, seg_ra;
    logic [GRP_W-1:0]  seg_rd;
    logic              seg_we;
    logic [PT_AW-1:0]  walk_pt_ra, pt_ra, pt_wa, wb_addr;
    logic [ENT_W-1:0]  pt_rd, pt_wd, wb_data;
    logic              pt_we, wb_we;
    logic              mnt_seg, mnt_pt;
    logic [31:0]       rdata_q;
    logic              rvalid_q;

    assign mnt_seg = mnt_en && !mnt_sel;
    assign mnt_pt  = mnt_en && mnt_sel;

    assign seg_ra = mnt_seg ? mnt_idx[SEG_AW-1:0] : walk_seg_ra;
    assign seg_we = mnt_seg && mnt_we;

    assign pt_ra = mnt_pt ? mnt_idx[PT_AW-1:0] : walk_pt_ra;
    assign pt_we = (mnt_pt && mnt_we) || wb_we;
    assign pt_wa = mnt_en ? mnt_idx[PT_AW-1:0] : wb_addr;
    assign pt_wd = mnt_en ? mnt_wdata : wb_data;

    segmmu_table #(.AW(SEG_AW), .DW(GRP_W)) seg_tbl_i (
        .clk   (clk),
        .raddr (seg_ra),
        .rdata (seg_rd),
        .we    (seg_we),
        .waddr (mnt_idx[SEG_AW-1:0]),
        .wdata (mnt_wdata[GRP_W-1:0])
    );

    segmmu_table #(.AW(PT_AW), .DW(ENT_W)) pte_tbl_i (
        .clk   (clk),
        .raddr (pt_ra),
        .rdata (pt_rd),
        .we    (pt_we),
        .waddr (pt_wa),
        .wdata (pt_wd)
    );

    segmmu_walk #(.CTX_W(CTX_W), .VSEG_W(VSEG_W), .GRP_W(GRP_W)) walk_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_va      (req_va),
        .req_write   (req_write),
        .req_user    (req_user),
        .ctx         (ctx),
        .stall       (mnt_en),
        .req_ready   (req_ready),
        .seg_raddr   (walk_seg_ra),
        .seg_rdata   (seg_rd),
        .pt_raddr    (walk_pt_ra),
        .pt_rdata    (pt_rd),
        .wb_we       (wb_we),
        .wb_addr     (wb_addr),
        .wb_data     (wb_data),
        .done        (done),
        .fault       (fault),
        .fault_cause (fault_cause),
        .pa          (pa),
        .nc          (nc),
        .space       (space)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= mnt_en && !mnt_we;
            if (mnt_en && !mnt_we)
                rdata_q <= mnt_sel ? pt_rd : {{(32-GRP_W){1'b0}}, seg_rd};
        end
    end

    assign mnt_rdata  = rdata_q;
    assign mnt_rvalid = rvalid_q;

    // R10
    no_wb_during_mnt_chk: assert property (@(posedge clk) disable iff (rst)
        wb_we |-> !mnt_en);

    // R9
    rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
        mnt_rvalid |-> $past(mnt_en && !mnt_we));

    // R10
    ready_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        mnt_en |-> !req_ready);
endmodule

// File: tb/segmap_xlate_tb_top.sv
module segmap_xlate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CTX_W  = 3;
    localparam int VSEG_W = 3;
    localparam int GRP_W  = 2;
    localparam int MIDX_W = 8;
    localparam int SEG_N  = 64;
    localparam int PT_N   = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CTX_W-1:0] ctx = '0;
    logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_va = '0;
    logic req_ready, done, fault, nc, mnt_rvalid;
    logic [1:0] fault_cause, space;
    logic [27:0] pa;
    logic mnt_en = 1'b0, mnt_we = 1'b0, mnt_sel = 1'b0;
    logic [MIDX_W-1:0] mnt_idx = '0;
    logic [31:0] mnt_wdata = '0;
    logic [31:0] mnt_rdata;

    int compared = 0;
    int mismatched = 0;
    bit started = 0;
    bit finished = 0;
    string cur_req = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    segmap_xlate #(.CTX_W(CTX_W), .VSEG_W(VSEG_W), .GRP_W(GRP_W), .MIDX_W(MIDX_W)) dut_i (
        .clk(clk), .rst(rst), .ctx(ctx), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_user(req_user), .req_ready(req_ready), .done(done),
        .fault(fault), .fault_cause(fault_cause), .pa(pa), .nc(nc), .space(space),
        .mnt_en(mnt_en), .mnt_we(mnt_we), .mnt_sel(mnt_sel), .mnt_idx(mnt_idx),
        .mnt_wdata(mnt_wdata), .mnt_rdata(mnt_rdata), .mnt_rvalid(mnt_rvalid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] ptm [PT_N];
    int          segm [SEG_N];
    bit          pend = 0;
    int          remain = 0;
    logic [31:0] q_va;
    bit          q_wr, q_usr;
    int          q_ctx;
    bit          m_done = 0, m_fault = 0, m_nc = 0, m_rvalid = 0;
    int          m_cause = 0, m_space = 0;
    logic [31:0] m_pa = '0, m_rdata = '0;

    task automatic resolve();
        int si, pi, top;
        logic [31:0] e;
        si  = q_ctx * 8 + int'((q_va >> 18) & 32'h7);
        pi  = segm[si] * 64 + int'((q_va >> 12) & 32'h3F);
        e   = ptm[pi];
        top = int'(q_va >> 29);
        m_fault = 1; m_pa = '0; m_nc = 0; m_space = 0;
        if (top != 0 && top != 7)           m_cause = 0;
        else if (e[31] == 1'b0)             m_cause = 1;
        else if (q_wr && e[30] == 1'b0)     m_cause = 2;
        else if (q_usr && e[29] == 1'b1)    m_cause = 3;
        else begin
            m_fault = 0; m_cause = 0;
            m_pa    = ((e & 32'hFFFF) << 12) | (q_va & 32'hFFF);
            m_nc    = e[28];
            m_space = int'((e >> 26) & 32'h3);
            ptm[pi] = e | 32'h0200_0000 | (q_wr ? 32'h0100_0000 : 32'h0);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            pend = 0; m_done = 0; m_rvalid = 0;
        end else begin
            m_done = 0; m_rvalid = 0;
            if (mnt_en) begin
                if (mnt_we) begin
                    if (mnt_sel) ptm[int'(mnt_idx)] = mnt_wdata;
                    else segm[int'(mnt_idx) % SEG_N] = int'(mnt_wdata & 32'h3);
                end else begin
                    m_rvalid = 1;
                    m_rdata  = mnt_sel ? ptm[int'(mnt_idx)] : 32'(segm[int'(mnt_idx) % SEG_N]);
                end
            end
            if (pend) begin
                if (mnt_en) remain = 2;
                else begin
                    remain--;
                    if (remain == 0) begin
                        resolve();
                        m_done = 1;
                        pend   = 0;
                    end
                end
            end else if (req_valid && !mnt_en) begin
                pend = 1; remain = 2;
                q_va = req_va; q_wr = req_write; q_usr = req_user; q_ctx = int'(ctx);
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !rst && !finished) begin
            chk(done == m_done, cur_req, "done", 32'(done), 32'(m_done));
            chk(req_ready == (!pend && !mnt_en), cur_req, "req_ready", 32'(req_ready), 32'(!pend && !mnt_en));
            chk(mnt_rvalid == m_rvalid, cur_req, "mnt_rvalid", 32'(mnt_rvalid), 32'(m_rvalid));
            if (m_rvalid)
                chk(mnt_rdata == m_rdata, cur_req, "mnt_rdata", mnt_rdata, m_rdata);
            if (m_done) begin
                chk(fault == m_fault, cur_req, "fault", 32'(fault), 32'(m_fault));
                if (m_fault)
                    chk(int'(fault_cause) == m_cause, cur_req, "cause", 32'(fault_cause), 32'(m_cause));
                chk(pa == m_pa[27:0], cur_req, "pa", 32'(pa), m_pa);
                chk(int'(space) == m_space && nc == m_nc, cur_req, "attr",
                    {29'd0, nc, space}, 32'({m_nc, m_space[1:0]}));
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic mwr(input bit sel, input int idx, input logic [31:0] data);
        @(posedge clk); #1;
        mnt_en = 1; mnt_we = 1; mnt_sel = sel; mnt_idx = MIDX_W'(idx); mnt_wdata = data;
        @(posedge clk); #1;
        mnt_en = 0; mnt_we = 0;
    endtask

    task automatic mrd(input bit sel, input int idx, input logic [31:0] exp, input string req);
        @(posedge clk); #1;
        mnt_en = 1; mnt_we = 0; mnt_sel = sel; mnt_idx = MIDX_W'(idx);
        @(posedge clk); #1;
        mnt_en = 0;
        @(negedge clk);
        chk(mnt_rvalid == 1'b1, req, "readback valid", 32'(mnt_rvalid), 32'd1);
        chk(mnt_rdata == exp, req, "readback data", mnt_rdata, exp);
    endtask

    task automatic xlate(input logic [31:0] va, input bit wr, input bit usr, input int c,
                         input bit ef, input int ecause, input logic [27:0] epa,
                         input bit enc, input int esp, input string req);
        int n;
        @(posedge clk); #1;
        ctx = CTX_W'(c); req_va = va; req_write = wr; req_user = usr; req_valid = 1;
        @(posedge clk); #1;
        req_valid = 0;
        n = 0;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(n == 3, "R8", "done latency", 32'(n), 32'd3);
        chk(fault == ef, req, "fault", 32'(fault), 32'(ef));
        if (ef) chk(int'(fault_cause) == ecause, req, "cause", 32'(fault_cause), 32'(ecause));
        chk(pa == epa, req, "pa", 32'(pa), 32'(epa));
        chk(nc == enc && int'(space) == esp, req, "attr", {29'd0, nc, space}, 32'({enc, 2'(esp)}));
    endtask

    // ---------------- test sequence ----------------
    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        started = 1;
        @(negedge clk);
        chk(done == 0 && fault == 0 && mnt_rvalid == 0, "R11", "reset outputs",
            {29'd0, done, fault, mnt_rvalid}, 32'd0);
        chk(req_ready == 1, "R11", "reset ready", 32'(req_ready), 32'd1);

        cur_req = "R9";
        for (int i = 0; i < SEG_N; i++) mwr(0, i, 32'd0);
        for (int i = 0; i < PT_N; i++)  mwr(1, i, 32'd0);

        // context 1, segment 2 -> group 3; page 9 -> entry 201
        mwr(0, 10, 32'd3);
        mwr(1, 201, 32'hD400_1234);

        cur_req = "R6";
        xlate(32'h0008_9ABC, 0, 1, 1, 0, 0, 28'h123_4ABC, 1, 1, "R6");
        mrd(1, 201, 32'hD600_1234, "R7");

        cur_req = "R7";
        xlate(32'h0008_9ABC, 1, 1, 1, 0, 0, 28'h123_4ABC, 1, 1, "R7");
        mrd(1, 201, 32'hD700_1234, "R7");

        cur_req = "R1";
        xlate(32'h2008_9ABC, 1, 0, 1, 1, 0, 28'h0, 0, 0, "R1");
        xlate(32'hC008_9ABC, 0, 0, 1, 1, 0, 28'h0, 0, 0, "R1");
        mrd(1, 201, 32'hD700_1234, "R1");
        xlate(32'hE008_9ABC, 0, 0, 1, 0, 0, 28'h123_4ABC, 1, 1, "R1");

        cur_req = "R3";
        mwr(1, 202, 32'h6000_1111);
        xlate(32'h0008_AABC, 1, 1, 1, 1, 1, 28'h0, 0, 0, "R3");
        mrd(1, 202, 32'h6000_1111, "R7");

        cur_req = "R4";
        mwr(1, 203, 32'hA000_2222);
        xlate(32'h0008_BABC, 1, 1, 1, 1, 2, 28'h0, 0, 0, "R4");
        mrd(1, 203, 32'hA000_2222, "R4");

        cur_req = "R5";
        xlate(32'h0008_BABC, 0, 1, 1, 1, 3, 28'h0, 0, 0, "R5");
        xlate(32'h0008_BABC, 0, 0, 1, 0, 0, 28'h222_2ABC, 0, 0, "R5");
        mrd(1, 203, 32'hA200_2222, "R7");

        cur_req = "R2";
        xlate(32'h0008_9ABC, 0, 1, 2, 1, 1, 28'h0, 0, 0, "R2");
        mwr(0, 18, 32'hFFFF_FFFD);
        mrd(0, 18, 32'h0000_0001, "R9");
        mwr(1, 73, 32'h8000_0055);
        xlate(32'h0008_9ABC, 0, 1, 2, 0, 0, 28'h005_5ABC, 0, 0, "R2");

        // stall with read then write of the entry being translated
        cur_req = "R10";
        @(posedge clk); #1;
        ctx = 3'd1; req_va = 32'h0008_9ABC; req_write = 0; req_user = 0; req_valid = 1;
        @(posedge clk); #1;
        req_valid = 0;
        mnt_en = 1; mnt_we = 0; mnt_sel = 1; mnt_idx = 8'd201;
        @(posedge clk); #1;
        mnt_we = 1; mnt_wdata = 32'h8000_0077;
        @(negedge clk);
        chk(mnt_rdata == 32'hD700_1234, "R10", "read during stall", mnt_rdata, 32'hD700_1234);
        @(posedge clk); #1;
        mnt_en = 0; mnt_we = 0;
        n = 0;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(n == 3, "R10", "done after stall", 32'(n), 32'd3);
        chk(fault == 0 && pa == 28'h007_7ABC, "R10", "pa uses new entry", 32'(pa), 32'h0007_7ABC);
        mrd(1, 201, 32'h8200_0077, "R10");

        // request held while maintenance is active
        @(posedge clk); #1;
        mnt_en = 1; mnt_we = 0; mnt_sel = 0; mnt_idx = 8'd10;
        ctx = 3'd1; req_va = 32'h0008_9ABC; req_write = 0; req_user = 1; req_valid = 1;
        @(negedge clk);
        chk(req_ready == 0, "R10", "ready during maintenance", 32'(req_ready), 32'd0);
        @(posedge clk); #1;
        mnt_en = 0;
        @(posedge clk); #1;
        req_valid = 0;
        n = 0;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1 && fault == 0 && pa == 28'h007_7ABC, "R10", "held request result",
            32'(pa), 32'h0007_7ABC);

        repeat (4) @(posedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule